// File: doc/BRIEF.md
# Shadowed Multichannel Configuration Register File

This block holds the configuration state of a four-channel converter and is reached over a simple byte-wide register bus: an 8-bit address, 8-bit write data, a write strobe, a read strobe and 8-bit read data. Some registers are global and have one copy. Others are local: each channel keeps its own copy, and a channel-select register picks which copies an access reaches. A single write to a local register can therefore update several channels at once. A read of a local register returns one channel's copy.

Registers in the shadowed range (0x08 to 0x3E) each have two copies: a staging copy that the bus writes and reads back, and an active copy that drives the control outputs. Writing a value with bit 0 set to the transfer address copies every staged value into its active copy on the same clock edge. The transfer bit clears itself. Two global registers outside the shadowed range take effect as soon as they are written.

Implemented map: 0x00 and 0x01 are immediate globals. 0x05 is channel select. 0x08 to 0x0B are four local shadowed registers. 0x3A and 0x3B are two global shadowed registers. 0xFF is the transfer command.

Top module: `cfg_shadow_regfile`

## Requirements
- R1: On reset the register contents are as follows.
  - Local registers 0x08, 0x09, 0x0A and 0x0B hold 0x11, 0x22, 0x33 and 0x44 in every channel, both staged and active.
  - Global shadowed registers 0x3A and 0x3B hold 0xA0 and 0x01.
  - Register 0x00 holds 0x00 and register 0x01 holds 0x0C.
  - Channel select holds 0xF.
- R2: A write to a shadowed address changes the value read back from that address on the following cycles. It leaves `loc_act_o` and `glb_act_o` unchanged.
- R3: A write to 0xFF with data bit 0 set copies every staged register into its active copy at that clock edge. A write to 0xFF with bit 0 clear changes nothing.
- R4: A read of 0xFF always returns 0x00, so the transfer bit reads back as cleared.
- R5: Register 0x05 bit i selects channel i (bit 0 is channel A). The register reads back in bits [3:0], and bits [7:4] read as 0.
- R6: A write to a local register updates that register in every selected channel. With no channel selected, the write changes no local register.
- R7: A read of a local register returns the selected channel's staged copy when exactly one select bit is set. In every other case it returns channel A's copy.
- R8: Global registers (0x00, 0x01, 0x3A, 0x3B) have one copy. Their writes and reads behave the same whatever channel select holds.
- R9: Unused bits are stored and read as 0. The used bits are 0x0A [5:0], 0x3B [3:0], 0x00 [6:0] and 0x01 [3:0].
- R10: A write to 0x00 or 0x01 appears on `cfg_imm_o` on the next cycle, with no transfer needed. 0x00 drives bits [7:0] and 0x01 drives bits [15:8].
- R11: A write to an unimplemented address changes no register, and a read of such an address returns 0x00.
- R12: `bus_rdata` is 0x00 whenever `bus_rd` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_wr | input | 1 | Write strobe, one write per cycle it is high |
| bus_rd | input | 1 | Read strobe; read data is combinational in the same cycle |
| bus_rdata | output | 8 | Read data |
| loc_act_o | output | NCH*NLOC*8 | Active local registers; channel c, register k at bits [(c*NLOC+k)*8 +: 8] |
| glb_act_o | output | NGLB*8 | Active global shadowed registers; register g at bits [g*8 +: 8] |
| cfg_imm_o | output | 16 | Immediate registers: {0x01, 0x00} |

## Verification
The assertions assume that `bus_wr` and `bus_rd` are never high in the same cycle. They also assume that the address and data are stable for the whole cycle a strobe is high, since the transfer and immediate-write properties sample those inputs at the clock edge. The bench drives every input on the falling edge and raises at most one strobe per cycle. It sweeps all sixteen channel-select patterns, including zero and multi-channel selections, and all 256 addresses for the unimplemented case.

// File: rtl/cfg_rf_pkg.sv
package cfg_rf_pkg;

  localparam int unsigned DW = 8;

  localparam logic [7:0] ADDR_CFG0  = 8'h00;
  localparam logic [7:0] ADDR_CFG1  = 8'h01;
  localparam logic [7:0] ADDR_CHSEL = 8'h05;
  localparam logic [7:0] ADDR_XFER  = 8'hFF;
  localparam logic [7:0] LOC_BASE   = 8'h08;
  localparam logic [7:0] GLB_BASE   = 8'h3A;

  localparam logic [7:0] CFG0_MASK = 8'h7F;
  localparam logic [7:0] CFG0_DFLT = 8'h00;
  localparam logic [7:0] CFG1_MASK = 8'h0F;
  localparam logic [7:0] CFG1_DFLT = 8'h0C;

  function automatic logic [7:0] loc_mask(input int k);
    return (k == 2) ? 8'h3F : 8'hFF;
  endfunction

  function automatic logic [7:0] loc_dflt(input int k);
    logic [7:0] v;
    v = 8'(17 * (k + 1));
    return v & loc_mask(k);
  endfunction

  function automatic logic [7:0] glb_mask(input int g);
    return (g == 1) ? 8'h0F : 8'hFF;
  endfunction

  function automatic logic [7:0] glb_dflt(input int g);
    logic [7:0] v;
    v = 8'(160 + g);
    return v & glb_mask(g);
  endfunction

endpackage

// File: rtl/cfg_addr_decode.sv
module cfg_addr_decode
  import cfg_rf_pkg::*;
#(
  parameter int NLOC = 4,
  parameter int NGLB = 2,
  localparam int LIW = (NLOC > 1) ? $clog2(NLOC) : 1,
  localparam int GIW = (NGLB > 1) ? $clog2(NGLB) : 1
) (
  input  logic [7:0]     addr,
  output logic           loc_hit,
  output logic [LIW-1:0] loc_idx,
  output logic           glb_hit,
  output logic [GIW-1:0] glb_idx,
  output logic           cfg0_hit,
  output logic           cfg1_hit,
  output logic           sel_hit,
  output logic           xfer_hit
);

  localparam int LOC_LO = int'(LOC_BASE);
  localparam int LOC_END = LOC_LO + NLOC;
  localparam int GLB_LO = int'(GLB_BASE);
  localparam int GLB_END = GLB_LO + NGLB;

  logic [7:0] loc_off, glb_off;
  int         a_int;

  always_comb begin
    a_int    = int'({24'd0, addr});
    loc_off  = addr - LOC_BASE;
    glb_off  = addr - GLB_BASE;
    loc_hit  = (a_int >= LOC_LO) && (a_int < LOC_END);
    glb_hit  = (a_int >= GLB_LO) && (a_int < GLB_END);
    loc_idx  = loc_off[LIW-1:0];
    glb_idx  = glb_off[GIW-1:0];
    cfg0_hit = (addr == ADDR_CFG0);
    cfg1_hit = (addr == ADDR_CFG1);
    sel_hit  = (addr == ADDR_CHSEL);
    xfer_hit = (addr == ADDR_XFER);
  end

endmodule

// File: rtl/cfg_shadow_reg.sv
module cfg_shadow_reg #(
  parameter logic [7:0] DFLT = 8'h00,
  parameter logic [7:0] MASK = 8'hFF
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [7:0] wdata,
  input  logic       xfer,
  output logic [7:0] stg_o,
  output logic [7:0] act_o
);

  logic [7:0] stg_q, stg_d, act_q, act_d;

  always_comb begin
    stg_d = stg_q;
    act_d = act_q;
    if (wr_en) stg_d = wdata & MASK;
    if (xfer)  act_d = stg_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg_q <= DFLT;
      act_q <= DFLT;
    end else begin
      stg_q <= stg_d;
      act_q <= act_d;
    end
  end

  assign stg_o = stg_q;
  assign act_o = act_q;

endmodule

// File: rtl/cfg_shadow_regfile.sv
module cfg_shadow_regfile
  import cfg_rf_pkg::*;
#(
  parameter int NCH  = 4,
  parameter int NLOC = 4,
  parameter int NGLB = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [7:0]             bus_addr,
  input  logic [7:0]             bus_wdata,
  input  logic                   bus_wr,
  input  logic                   bus_rd,
  output logic [7:0]             bus_rdata,
  output logic [NCH*NLOC*DW-1:0] loc_act_o,
  output logic [NGLB*DW-1:0]     glb_act_o,
  output logic [2*DW-1:0]        cfg_imm_o
);

  localparam int LIW = (NLOC > 1) ? $clog2(NLOC) : 1;
  localparam int GIW = (NGLB > 1) ? $clog2(NGLB) : 1;
  localparam int CIW = (NCH > 1) ? $clog2(NCH) : 1;
  localparam logic [NCH-1:0] SEL_DFLT = '1;

  logic           loc_hit, glb_hit, cfg0_hit, cfg1_hit, sel_hit, xfer_hit;
  logic [LIW-1:0] loc_idx;
  logic [GIW-1:0] glb_idx;

  cfg_addr_decode #(.NLOC(NLOC), .NGLB(NGLB)) dec_i (
    .addr(bus_addr), .loc_hit(loc_hit), .loc_idx(loc_idx),
    .glb_hit(glb_hit), .glb_idx(glb_idx), .cfg0_hit(cfg0_hit),
    .cfg1_hit(cfg1_hit), .sel_hit(sel_hit), .xfer_hit(xfer_hit)
  );

  logic xfer_go;
  assign xfer_go = bus_wr & xfer_hit & bus_wdata[0];

  // immediate globals and channel select
  logic [NCH-1:0] sel_q, sel_d;
  logic [7:0]     cfg0_q, cfg0_d, cfg1_q, cfg1_d;

  always_comb begin
    sel_d  = sel_q;
    cfg0_d = cfg0_q;
    cfg1_d = cfg1_q;
    if (bus_wr && sel_hit)  sel_d  = bus_wdata[NCH-1:0];
    if (bus_wr && cfg0_hit) cfg0_d = bus_wdata & CFG0_MASK;
    if (bus_wr && cfg1_hit) cfg1_d = bus_wdata & CFG1_MASK;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q  <= SEL_DFLT;
      cfg0_q <= CFG0_DFLT;
      cfg1_q <= CFG1_DFLT;
    end else begin
      sel_q  <= sel_d;
      cfg0_q <= cfg0_d;
      cfg1_q <= cfg1_d;
    end
  end

  assign cfg_imm_o = {cfg1_q, cfg0_q};

  // shadowed local registers, one copy per channel
  logic [NCH*NLOC*DW-1:0] loc_stg;
  logic [NGLB*DW-1:0]     glb_stg;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    for (genvar k = 0; k < NLOC; k++) begin : g_reg
      logic wr_en;
      assign wr_en = bus_wr & loc_hit & sel_q[c] & (loc_idx == LIW'(k));
      cfg_shadow_reg #(.DFLT(loc_dflt(k)), .MASK(loc_mask(k))) reg_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wdata(bus_wdata),
        .xfer(xfer_go),
        .stg_o(loc_stg[(c*NLOC+k)*DW +: DW]),
        .act_o(loc_act_o[(c*NLOC+k)*DW +: DW])
      );
    end
  end

  // shadowed global registers, single copy
  for (genvar g = 0; g < NGLB; g++) begin : g_glb
    logic wr_en;
    assign wr_en = bus_wr & glb_hit & (glb_idx == GIW'(g));
    cfg_shadow_reg #(.DFLT(glb_dflt(g)), .MASK(glb_mask(g))) reg_i (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wdata(bus_wdata),
      .xfer(xfer_go),
      .stg_o(glb_stg[g*DW +: DW]),
      .act_o(glb_act_o[g*DW +: DW])
    );
  end

  // read channel: the single selected channel, otherwise channel A
  logic [CIW-1:0] rd_ch;

  always_comb begin
    rd_ch = '0;
    if ($countones(sel_q) == 1) begin
      for (int i = 0; i < NCH; i++) begin
        if (sel_q[i]) rd_ch = CIW'(i);
      end
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_rd) begin
      if (loc_hit)
        bus_rdata = loc_stg[(int'(rd_ch)*NLOC + int'(loc_idx))*DW +: DW];
      else if (glb_hit)
        bus_rdata = glb_stg[int'(glb_idx)*DW +: DW];
      else if (sel_hit)
        bus_rdata[NCH-1:0] = sel_q;
      else if (cfg0_hit)
        bus_rdata = cfg0_q;
      else if (cfg1_hit)
        bus_rdata = cfg1_q;
    end
  end

endmodule

// File: rtl/cfg_shadow_regfile_chk.sv
module cfg_shadow_regfile_chk
  import cfg_rf_pkg::*;
#(
  parameter int NCH  = 4,
  parameter int NLOC = 4,
  parameter int NGLB = 2
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic [7:0]             bus_addr,
  input logic [7:0]             bus_wdata,
  input logic                   bus_wr,
  input logic                   bus_rd,
  input logic [7:0]             bus_rdata,
  input logic [NCH*NLOC*DW-1:0] loc_act_o,
  input logic [NGLB*DW-1:0]     glb_act_o,
  input logic [2*DW-1:0]        cfg_imm_o,
  input logic [NCH*NLOC*DW-1:0] loc_stg,
  input logic [NGLB*DW-1:0]     glb_stg
);

  logic xfer_cmd;
  assign xfer_cmd = bus_wr && (bus_addr == ADDR_XFER) && bus_wdata[0];

  // R2: active outputs move only on a transfer command
  p_act_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !xfer_cmd |=> ($stable(loc_act_o) && $stable(glb_act_o)));

  // R3: transfer commits the staged image
  p_commit_r3: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_cmd |=> (loc_act_o == $past(loc_stg)) && (glb_act_o == $past(glb_stg)));

  // R4: transfer bit reads back cleared
  p_xfer_rd0_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == ADDR_XFER) |-> (bus_rdata == 8'h00));

  // R9: unused bits of 0x01 read as zero
  p_unused_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == ADDR_CFG1) |-> (bus_rdata[7:4] == 4'h0));

  // R10: immediate register written without transfer
  p_imm_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == ADDR_CFG0) |=>
      (cfg_imm_o[7:0] == ($past(bus_wdata) & CFG0_MASK)));

  // R12: idle read data
  p_idle_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |-> (bus_rdata == 8'h00));

endmodule

bind cfg_shadow_regfile cfg_shadow_regfile_chk #(.NCH(NCH), .NLOC(NLOC), .NGLB(NGLB)) chk_i (.*);

// File: tb/cfg_shadow_regfile_tb_top.sv
module cfg_shadow_regfile_tb_top;

  localparam int NCH = 4, NLOC = 4, NGLB = 2;

  logic clk, rst_n, bus_wr, bus_rd;
  logic [7:0] bus_addr, bus_wdata, bus_rdata;
  logic [NCH*NLOC*8-1:0] loc_act_o;
  logic [NGLB*8-1:0]     glb_act_o;
  logic [15:0]           cfg_imm_o;

  cfg_shadow_regfile #(.NCH(NCH), .NLOC(NLOC), .NGLB(NGLB)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
    .loc_act_o(loc_act_o), .glb_act_o(glb_act_o), .cfg_imm_o(cfg_imm_o)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  int n_vec = 0, n_bad = 0;
  bit done = 0;

  // bench model
  logic [7:0] m_lstg [NCH][NLOC];
  logic [7:0] m_lact [NCH][NLOC];
  logic [7:0] m_gstg [NGLB];
  logic [7:0] m_gact [NGLB];
  logic [7:0] m_c0, m_c1;
  logic [3:0] m_sel;

  function automatic logic [7:0] lmask(int k); return (k == 2) ? 8'h3F : 8'hFF; endfunction
  function automatic logic [7:0] gmask(int g); return (g == 1) ? 8'h0F : 8'hFF; endfunction

  task automatic model_reset();
    for (int c = 0; c < NCH; c++)
      for (int k = 0; k < NLOC; k++) begin
        m_lstg[c][k] = 8'((k + 1) * 17) & lmask(k);
        m_lact[c][k] = m_lstg[c][k];
      end
    m_gstg[0] = 8'hA0; m_gstg[1] = 8'h01;
    m_gact[0] = 8'hA0; m_gact[1] = 8'h01;
    m_c0 = 8'h00; m_c1 = 8'h0C; m_sel = 4'hF;
  endtask

  task automatic model_wr(logic [7:0] a, logic [7:0] d);
    if (a == 8'h00) m_c0 = d & 8'h7F;
    else if (a == 8'h01) m_c1 = d & 8'h0F;
    else if (a == 8'h05) m_sel = d[3:0];
    else if (a >= 8'h08 && a < 8'h08 + NLOC) begin
      for (int c = 0; c < NCH; c++)
        if (m_sel[c]) m_lstg[c][a - 8'h08] = d & lmask(int'(a - 8'h08));
    end else if (a >= 8'h3A && a < 8'h3A + NGLB)
      m_gstg[a - 8'h3A] = d & gmask(int'(a - 8'h3A));
    else if (a == 8'hFF && d[0]) begin
      m_lact = m_lstg;
      m_gact = m_gstg;
    end
  endtask

  function automatic logic [7:0] model_rd(logic [7:0] a);
    int ch = 0;
    if ($countones(m_sel) == 1)
      for (int i = 0; i < NCH; i++) if (m_sel[i]) ch = i;
    if (a == 8'h00) return m_c0;
    if (a == 8'h01) return m_c1;
    if (a == 8'h05) return {4'h0, m_sel};
    if (a >= 8'h08 && a < 8'h08 + NLOC) return m_lstg[ch][a - 8'h08];
    if (a >= 8'h3A && a < 8'h3A + NGLB) return m_gstg[a - 8'h3A];
    return 8'h00;
  endfunction

  function automatic bit implemented(logic [7:0] a);
    return a == 8'h00 || a == 8'h01 || a == 8'h05 ||
           (a >= 8'h08 && a < 8'h08 + NLOC) ||
           (a >= 8'h3A && a < 8'h3A + NGLB);
  endfunction

  task automatic wr(logic [7:0] a, logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1; bus_rd = 1'b0;
    @(negedge clk);
    bus_wr = 1'b0;
    model_wr(a, d);
  endtask

  task automatic rd_chk(logic [7:0] a, logic [7:0] exp, string tag);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1; bus_wr = 1'b0;
    #5;
    n_vec++;
    if (bus_rdata !== exp) begin
      n_bad++;
      $display("FAIL %s read 0x%02h: got 0x%02h expected 0x%02h", tag, a, bus_rdata, exp);
    end
    bus_rd = 1'b0;
  endtask

  task automatic out_chk(string tag);
    logic [NCH*NLOC*8-1:0] el;
    logic [NGLB*8-1:0]     eg;
    logic [15:0]           ei;
    for (int c = 0; c < NCH; c++)
      for (int k = 0; k < NLOC; k++) el[(c*NLOC+k)*8 +: 8] = m_lact[c][k];
    for (int g = 0; g < NGLB; g++) eg[g*8 +: 8] = m_gact[g];
    ei = {m_c1, m_c0};
    #1;
    n_vec++;
    if (loc_act_o !== el || glb_act_o !== eg || cfg_imm_o !== ei) begin
      n_bad++;
      $display("FAIL %s outputs: got loc=%h glb=%h imm=%h expected loc=%h glb=%h imm=%h",
               tag, loc_act_o, glb_act_o, cfg_imm_o, el, eg, ei);
    end
  endtask

  task automatic all_rd(string tag);
    for (int a = 0; a < 256; a++)
      if (implemented(8'(a))) rd_chk(8'(a), model_rd(8'(a)), tag);
  endtask

  initial begin
    rst_n = 1'b0; bus_wr = 1'b0; bus_rd = 1'b0; bus_addr = '0; bus_wdata = '0;
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    out_chk("R1");
    all_rd("R1");

    // R5, R6, R7, R2: every channel-select pattern
    for (int s = 0; s < 16; s++) begin
      int k = s % NLOC;
      wr(8'h05, 8'(8'hF0 | s));
      rd_chk(8'h05, 8'(s), "R5");
      wr(8'(8'h08 + k), 8'(s * 37 + 11));
      for (int c = 0; c < NCH; c++) begin
        wr(8'h05, 8'(1 << c));
        rd_chk(8'(8'h08 + k), model_rd(8'(8'h08 + k)), "R6");
      end
      wr(8'h05, 8'h06);
      rd_chk(8'(8'h08 + k), m_lstg[0][k], "R7");
      wr(8'h05, 8'h00);
      rd_chk(8'(8'h08 + k), m_lstg[0][k], "R7");
      out_chk("R2");
    end

    // R3, R4: transfer command
    wr(8'hFF, 8'h02);
    out_chk("R3");
    rd_chk(8'hFF, 8'h00, "R4");
    wr(8'hFF, 8'h01);
    out_chk("R3");
    rd_chk(8'hFF, 8'h00, "R4");

    // R8, R9: globals independent of channel select
    for (int s = 0; s < 3; s++) begin
      logic [3:0] sv = (s == 0) ? 4'h0 : (s == 1) ? 4'hF : 4'h3;
      wr(8'h05, {4'h0, sv});
      wr(8'h3A, 8'(8'h5C + s));
      wr(8'h3B, 8'hF0 | 8'(s));
      wr(8'h05, 8'h00);
      rd_chk(8'h3A, 8'(8'h5C + s), "R8");
      wr(8'h05, 8'h0F);
      rd_chk(8'h3B, 8'(s), "R9");
    end
    wr(8'h3B, 8'hFF);
    rd_chk(8'h3B, 8'h0F, "R9");
    wr(8'h0A, 8'hFF);
    rd_chk(8'h0A, 8'h3F, "R9");
    out_chk("R8");
    wr(8'hFF, 8'hFF);
    out_chk("R8");

    // R10: immediate registers
    wr(8'h05, 8'h02);
    wr(8'h00, 8'hFF);
    out_chk("R10");
    rd_chk(8'h00, 8'h7F, "R10");
    wr(8'h01, 8'hFF);
    out_chk("R10");
    rd_chk(8'h01, 8'h0F, "R9");
    wr(8'h01, 8'h35);
    rd_chk(8'h01, 8'h05, "R10");

    // R11: unimplemented addresses
    for (int a = 0; a < 256; a++) begin
      if (!implemented(8'(a)) && a != 8'hFF) begin
        wr(8'(a), 8'hFF);
        rd_chk(8'(a), 8'h00, "R11");
      end
    end
    out_chk("R11");
    all_rd("R11");
    wr(8'hFF, 8'h01);
    out_chk("R11");

    // R12: no read strobe
    @(negedge clk);
    bus_addr = 8'h08; bus_rd = 1'b0;
    #5;
    n_vec++;
    if (bus_rdata !== 8'h00) begin
      n_bad++;
      $display("FAIL R12 idle rdata: got 0x%02h expected 0x00", bus_rdata);
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

endmodule